// File: doc/BRIEF.md
# Order-Preserving Tour Splice Unit

This block joins two parent tours into one offspring tour. Each tour is an ordering of N city indices. The offspring keeps the leading k cities of the first parent, in their positions. Every remaining slot is filled with a city the prefix did not use, and these cities keep the order they have in the second parent. Because the tail is built by walking the second parent and skipping cities already placed, the offspring always holds each city exactly once.

A request enters through a valid/ready handshake that carries both parents and the cut point together. The unit takes one request at a time. While it is working it holds `in_ready` low, so a producer is stalled and nothing it presents is taken. The result side has no back-pressure. When the offspring is complete the unit raises `done` for one cycle. The offspring then stays on `child` until the next request is accepted, so a consumer may read it at any time in that window.

Internally, a bitmap of used cities is loaded from the prefix on the accepting edge. The second parent is then scanned one element per clock, and each city whose bit is still clear is appended.

Top module: `perm_splice`

## Requirements
- R1: A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle. While `in_ready` is low, `in_valid` and the request fields have no effect on the result.
- R2: Tour position i occupies bits [i*IW +: IW] of `parent_a`, `parent_b` and `child`, where IW = clog2(N). For every position i < k, the offspring holds the city that `parent_a` has at position i.
- R3: Positions k to N-1 hold the cities absent from the prefix, in the order in which they appear in `parent_b`.
- R4: When both parents are valid tours, the offspring contains every city from 0 to N-1 exactly once.
- R5: With k = 0 the offspring equals `parent_b`.
- R6: With k = N the offspring equals `parent_a`. A value of `cut` above N is treated as N.
- R7: `done` is high for exactly one cycle, starting N clock edges after the accepting edge. `in_ready` is high again in the cycle after `done`.
- R8: `child` keeps its value from `done` until the next request is accepted.
- R9: After reset, `done` is low, `in_ready` is high and `child` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| parent_a | input | N*IW | Tour that supplies the prefix |
| parent_b | input | N*IW | Tour that supplies the order of the tail |
| cut | input | clog2(N+1) | Prefix length k |
| child | output | N*IW | Offspring tour |
| done | output | 1 | One-cycle strobe marking the offspring as complete |

## Verification
A stale or wrongly loaded used-city bitmap shows up at the `done` strobe. It appears as a repeated or missing city in the tail, or as a tail order that departs from `parent_b`, and every offspring is compared in full against a model built from the requirements. A scan counter that is off by one moves `done` away from edge N or leaves a tail slot unfilled, so the latency is measured on every operation. Requests offered while the unit is busy, and idle cycles after `done`, show whether stray input reaches the result or the held value drifts.

// File: rtl/splice_pkg.sv
package splice_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_FIN  = 2'd2
  } splice_state_t;
endpackage

// File: rtl/splice_used_map.sv
module splice_used_map #(
  parameter int N = 8,
  localparam int IW = $clog2(N),
  localparam int KW = $clog2(N + 1)
) (
  input  logic [N*IW-1:0] prefix_src,
  input  logic [KW-1:0]   cut,
  output logic [N-1:0]    used
);
  for (genvar c = 0; c < N; c++) begin : g_city
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
        if ((KW'(i) < cut) && (prefix_src[i*IW +: IW] == IW'(c))) hit = 1'b1;
      end
    end
    assign used[c] = hit;
  end
endmodule

// File: rtl/splice_seq.sv
module splice_seq
  import splice_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic          scan_en,
  output logic [IW-1:0] rd_idx,
  output logic          idle,
  output logic          fin
);
  splice_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rd_idx  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_SCAN;
          rd_idx  <= '0;
        end
        S_SCAN: begin
          if (rd_idx == IW'(N - 1)) state_q <= S_FIN;
          else rd_idx <= rd_idx + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign scan_en = (state_q == S_SCAN);
  assign idle    = (state_q == S_IDLE);
  assign fin     = (state_q == S_FIN);

  // R7
  scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && rd_idx == IW'(N - 1)) |=> fin);

  // R1
  no_reaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !idle);
endmodule

// File: rtl/perm_splice.sv
module perm_splice
  import splice_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = $clog2(N),
  localparam int KW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N*IW-1:0] parent_a,
  input  logic [N*IW-1:0] parent_b,
  input  logic [KW-1:0] cut,
  output logic [N*IW-1:0] child,
  output logic          done
);
  logic              accept;
  logic [KW-1:0]     cut_eff;
  logic [N-1:0]      used_init;
  logic [N-1:0]      used_q;
  logic [N*IW-1:0]   pb_q;
  logic [KW-1:0]     wr_q;
  logic [IW-1:0]     child_q [N];
  logic              scan_en, idle, fin;
  logic [IW-1:0]     rd_idx;
  logic [IW-1:0]     scan_city;
  logic              take;

  assign accept  = in_valid && in_ready;
  assign cut_eff = (cut > KW'(N)) ? KW'(N) : cut;

  splice_used_map #(.N(N)) u_map (
    .prefix_src (parent_a),
    .cut        (cut_eff),
    .used       (used_init)
  );

  splice_seq #(.N(N)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .scan_en (scan_en),
    .rd_idx  (rd_idx),
    .idle    (idle),
    .fin     (fin)
  );

  assign scan_city = pb_q[rd_idx*IW +: IW];
  assign take      = scan_en && !used_q[scan_city];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      pb_q   <= '0;
      wr_q   <= '0;
      for (int i = 0; i < N; i++) child_q[i] <= '0;
    end else if (accept) begin
      used_q <= used_init;
      pb_q   <= parent_b;
      wr_q   <= cut_eff;
      for (int i = 0; i < N; i++)
        child_q[i] <= (KW'(i) < cut_eff) ? parent_a[i*IW +: IW] : '0;
    end else if (take) begin
      used_q[scan_city] <= 1'b1;
      wr_q              <= wr_q + 1'b1;
      for (int i = 0; i < N; i++)
        if (KW'(i) == wr_q) child_q[i] <= scan_city;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) child[i*IW +: IW] = child_q[i];
  end

  assign in_ready = idle;
  assign done     = fin;

  // R4
  all_cities_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(used_q) == N));

  // R3
  tail_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_q == KW'(N)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));

  // R8
  hold_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !scan_en) |=> $stable(child));
endmodule

// File: tb/perm_splice_test.sv
module perm_splice_test;
  localparam int N  = 8;
  localparam int IW = $clog2(N);
  localparam int KW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*IW-1:0] parent_a = '0, parent_b = '0, child;
  logic [KW-1:0] cut = '0;
  logic done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  perm_splice #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .parent_a(parent_a), .parent_b(parent_b), .cut(cut),
    .child(child), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N*IW-1:0] gen(input int a, input int b);
    logic [N*IW-1:0] p;
    for (int i = 0; i < N; i++) p[i*IW +: IW] = IW'((a * i + b) % N);
    return p;
  endfunction

  function automatic logic [N*IW-1:0] model(input logic [N*IW-1:0] pa, input logic [N*IW-1:0] pb, input int k);
    logic [N*IW-1:0] r;
    bit taken [N];
    int w;
    int kk;
    kk = (k > N) ? N : k;
    r = '0;
    for (int c = 0; c < N; c++) taken[c] = 1'b0;
    for (int i = 0; i < kk; i++) begin
      r[i*IW +: IW] = pa[i*IW +: IW];
      taken[pa[i*IW +: IW]] = 1'b1;
    end
    w = kk;
    for (int j = 0; j < N; j++) begin
      if (!taken[pb[j*IW +: IW]]) begin
        r[w*IW +: IW] = pb[j*IW +: IW];
        taken[pb[j*IW +: IW]] = 1'b1;
        w++;
      end
    end
    return r;
  endfunction

  function automatic bit is_perm(input logic [N*IW-1:0] p);
    bit seen [N];
    for (int c = 0; c < N; c++) seen[c] = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (seen[p[i*IW +: IW]]) return 1'b0;
      seen[p[i*IW +: IW]] = 1'b1;
    end
    return 1'b1;
  endfunction

  task automatic run_one(input logic [N*IW-1:0] pa, input logic [N*IW-1:0] pb, input int k, input bit poke);
    logic [N*IW-1:0] exp;
    int cyc;
    exp = model(pa, pb, k);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready when idle", 64'(in_ready), 64'd1);
    parent_a = pa; parent_b = pb; cut = KW'(k); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 40) begin
      if (poke && cyc == 0) begin
        chk(in_ready == 1'b0, "R1 busy not ready", 64'(in_ready), 64'd0);
        parent_a = ~pa; parent_b = ~pb; cut = '0; in_valid = 1'b1;
      end
      if (poke && cyc == 1) in_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == N, "R7 latency", 64'(cyc), 64'(N));
    if (k == 0)       chk(child == pb, "R5 copy of parent_b", 64'(child), 64'(pb));
    else if (k >= N)  chk(child == pa, "R6 copy of parent_a", 64'(child), 64'(pa));
    else              chk(child == exp, "R2 R3 offspring", 64'(child), 64'(exp));
    chk(is_perm(child), "R4 permutation", 64'(child), 64'(exp));
    @(negedge clk);
    chk(done == 1'b0 && in_ready == 1'b1, "R7 done single cycle", {62'd0, done, in_ready}, 64'd1);
    parent_a = ~pa; parent_b = pb; cut = '1;
    @(negedge clk);
    chk(child == exp, "R8 child held", 64'(child), 64'(exp));
  endtask

  initial begin
    #1;
    chk(done == 1'b0, "R9 done at reset", 64'(done), 64'd0);
    chk(in_ready == 1'b1, "R9 ready at reset", 64'(in_ready), 64'd1);
    chk(child == '0, "R9 child at reset", 64'(child), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // worked case from R2/R3: k=4
    begin
      logic [N*IW-1:0] a0, b0, e0;
      int av [N] = '{1, 7, 3, 2, 5, 6, 0, 4};
      int bv [N] = '{0, 2, 4, 1, 6, 5, 7, 3};
      int ev [N] = '{1, 7, 3, 2, 0, 4, 6, 5};
      for (int i = 0; i < N; i++) begin
        a0[i*IW +: IW] = IW'(av[i]);
        b0[i*IW +: IW] = IW'(bv[i]);
        e0[i*IW +: IW] = IW'(ev[i]);
      end
      chk(model(a0, b0, 4) == e0, "R3 model sanity", 64'(model(a0, b0, 4)), 64'(e0));
      run_one(a0, b0, 4, 1'b1);
      chk(child == e0, "R3 worked case", 64'(child), 64'(e0));
    end

    for (int a = 1; a < N; a += 2)
      for (int b = 0; b < N; b++)
        for (int c = 1; c < N; c += 2)
          for (int d = 0; d < N; d += 3)
            for (int k = 0; k < (1 << KW); k++)
              if (k <= N + 1 || (a == 1 && c == 1))
                run_one(gen(a, b), gen(c, d), k, (b == d));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule